// File: doc/BRIEF.md
# Keyed Register-Array Sorter

This block sorts a small set of tagged values by their tag. Each write carries a key and a code. The code is stored in the register slot whose index equals the key. The slots form a flat register array, so the occupancy of every slot is visible at the same time. A zero code marks a slot as empty. Writing a zero to a slot therefore removes whatever entry it held.

When a readout is started, the block takes a snapshot of which slots are occupied. It then emits the occupied entries in ascending key order, one per clock, with no cycles spent on empty slots. A priority encoder picks the lowest slot still pending and clears it once that slot is emitted. The last entry carries a flag.

During a readout, the store is frozen and further start requests are ignored. The stored contents survive a readout, so a later readout repeats the same list unless new writes arrive in between.

Top module: `keyed_reg_sorter`

## Requirements
- R1: While reset is low and after it is released, every slot is empty (all codes zero) and out_valid, out_last, out_key and out_code are 0. A readout straight after reset emits nothing.
- R2: While idle, a high wr_en with start low stores wr_code into slot wr_key. It takes effect at that clock edge. A later write to the same key replaces the earlier code.
- R3: A slot whose code is zero is empty and is never emitted, so writing code 0 to a key removes that entry. Every emitted entry has a non-zero code.
- R4: A start sampled high while idle snapshots occupancy. Occupied entries then appear on out_key/out_code with out_valid high, in strictly ascending key order. The first entry is registered at the clock edge after the one that samples start, and the rest follow on consecutive edges with no gaps.
- R5: out_last is high only together with the final occupied entry of a readout. out_valid is low in the cycle after out_last.
- R6: A start with no occupied slot completes at once and emits nothing. The block is idle again at the next clock edge and accepts a write there.
- R7: A write is ignored if it is presented in the same cycle as an accepted start, or while a readout is emitting. A start presented during a readout is also ignored.
- R8: A readout does not alter the store. Two readouts with no accepted write between them emit identical lists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| wr_en | input | 1 | Write strobe for one key/code pair |
| wr_key | input | KEY_W (4) | Slot index to write |
| wr_code | input | CODE_W (8) | Code to store; 0 empties the slot |
| start | input | 1 | Request a sorted readout |
| out_valid | output | 1 | An entry is presented on out_key/out_code |
| out_key | output | KEY_W (4) | Key of the presented entry |
| out_code | output | CODE_W (8) | Code of the presented entry |
| out_last | output | 1 | Presented entry is the final one of the readout |

## Verification
A write lands at the edge that samples it. The entry for a start sampled at edge E0 is registered at E0+1, and entry i is registered at E0+1+i. The bench samples on falling edges and tags every collected entry with the count of rising edges seen so far, so each entry's cycle is compared with the exact edge on which it is due.

Writes and a second start are injected on specific edges inside a 16-entry readout. A following readout then shows that the store did not change. Occupancy patterns are swept arithmetically and include the single-lowest and single-highest slot.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  // Readout controller phase
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_SCAN = 1'b1
  } rd_state_e;
endpackage

// File: rtl/sorter_slot_bank.sv
module sorter_slot_bank #(
  parameter int KEY_W  = 4,
  parameter int CODE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_go,
  input  logic [KEY_W-1:0]        wr_key,
  input  logic [CODE_W-1:0]       wr_code,
  input  logic [KEY_W-1:0]        rd_key,
  output logic [CODE_W-1:0]       rd_code,
  output logic [(1<<KEY_W)-1:0]   occ_mask
);
  localparam int SLOTS = 1 << KEY_W;

  logic [CODE_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  slot_en;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    // per-slot clock enable decoded from the write key
    assign slot_en[g] = wr_go && (wr_key == KEY_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[g] <= '0;
      else if (slot_en[g]) slot_q[g] <= wr_code;
    end

    // a non-zero code marks the slot as occupied
    assign occ_mask[g] = |slot_q[g];
  end

  assign rd_code = slot_q[rd_key];
endmodule

// File: rtl/sorter_lowest_pick.sv
module sorter_lowest_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     rest
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any  = |req;
    // drop the lowest set bit
    rest = req & (req - N'(1));
  end
endmodule

// File: rtl/sorter_readout_ctrl.sv
module sorter_readout_ctrl
  import sorter_pkg::*;
#(
  parameter int KEY_W  = 4,
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  wr_en,
  input  logic [(1<<KEY_W)-1:0] occ_mask,
  input  logic                  pick_any,
  input  logic [KEY_W-1:0]      pick_idx,
  input  logic [(1<<KEY_W)-1:0] pick_rest,
  input  logic [CODE_W-1:0]     rd_code,
  output logic [(1<<KEY_W)-1:0] pend,
  output logic                  wr_go,
  output logic                  busy,
  output logic                  out_valid,
  output logic [KEY_W-1:0]      out_key,
  output logic [CODE_W-1:0]     out_code,
  output logic                  out_last
);
  localparam int SLOTS = 1 << KEY_W;

  rd_state_e         state_q, state_d;
  logic [SLOTS-1:0]  pend_q, pend_d;
  logic              val_q, val_d;
  logic              last_q, last_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    val_d   = 1'b0;
    last_d  = 1'b0;
    key_d   = '0;
    code_d  = '0;
    case (state_q)
      RD_IDLE: begin
        if (start && (|occ_mask)) begin
          state_d = RD_SCAN;
          pend_d  = occ_mask;
        end
      end
      RD_SCAN: begin
        if (pick_any) begin
          val_d  = 1'b1;
          key_d  = pick_idx;
          code_d = rd_code;
          last_d = (pick_rest == '0);
          pend_d = pick_rest;
        end
        if (pick_rest == '0) state_d = RD_IDLE;
      end
      default: state_d = RD_IDLE;
    endcase
  end

  // writes only while idle and not on a start cycle
  assign wr_go = wr_en && (state_q == RD_IDLE) && !start;
  assign busy  = (state_q == RD_SCAN);
  assign pend  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      pend_q  <= '0;
      val_q   <= 1'b0;
      last_q  <= 1'b0;
      key_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      val_q   <= val_d;
      last_q  <= last_d;
      key_q   <= key_d;
      code_q  <= code_d;
    end
  end

  assign out_valid = val_q;
  assign out_last  = last_q;
  assign out_key   = key_q;
  assign out_code  = code_q;

  // R4: the encoder always points at a pending slot while scanning
  assert_pick_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pick_any && pend_q[pick_idx]));

  // R4: entries follow back to back with rising keys
  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && (out_key > $past(out_key))));

  // R5: nothing is presented right after the final entry
  assert_gap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);

  // R3: an emitted entry never carries the empty code
  assert_nonzero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code != '0));
endmodule

// File: rtl/keyed_reg_sorter.sv
module keyed_reg_sorter #(
  parameter int KEY_W  = 4,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              start,
  output logic              out_valid,
  output logic [KEY_W-1:0]  out_key,
  output logic [CODE_W-1:0] out_code,
  output logic              out_last
);
  localparam int SLOTS = 1 << KEY_W;

  logic              wr_go;
  logic              busy;
  logic [SLOTS-1:0]  occ_mask;
  logic [SLOTS-1:0]  pend;
  logic [SLOTS-1:0]  pick_rest;
  logic              pick_any;
  logic [KEY_W-1:0]  pick_idx;
  logic [CODE_W-1:0] rd_code;

  sorter_slot_bank #(.KEY_W(KEY_W), .CODE_W(CODE_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (wr_go),
    .wr_key   (wr_key),
    .wr_code  (wr_code),
    .rd_key   (pick_idx),
    .rd_code  (rd_code),
    .occ_mask (occ_mask)
  );

  sorter_lowest_pick #(.N(SLOTS), .IDX_W(KEY_W)) u_pick (
    .req  (pend),
    .any  (pick_any),
    .idx  (pick_idx),
    .rest (pick_rest)
  );

  sorter_readout_ctrl #(.KEY_W(KEY_W), .CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_en     (wr_en),
    .occ_mask  (occ_mask),
    .pick_any  (pick_any),
    .pick_idx  (pick_idx),
    .pick_rest (pick_rest),
    .rd_code   (rd_code),
    .pend      (pend),
    .wr_go     (wr_go),
    .busy      (busy),
    .out_valid (out_valid),
    .out_key   (out_key),
    .out_code  (out_code),
    .out_last  (out_last)
  );

  // R7: the store cannot change while a readout is emitting
  assert_store_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(occ_mask));

  // R3: only occupied slots are ever presented
  assert_emit_occupied_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ_mask[out_key]);
endmodule

// File: tb/sim_keyed_reg_sorter.sv
`timescale 1ns/1ps
module sim_keyed_reg_sorter;
  localparam int KW = 4;
  localparam int CW = 8;
  localparam int NS = 1 << KW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [KW-1:0] wr_key = '0;
  logic [CW-1:0] wr_code = '0;
  logic start = 1'b0;
  logic out_valid, out_last;
  logic [KW-1:0] out_key;
  logic [CW-1:0] out_code;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int c0 = 0;
  bit done = 1'b0;
  int refm [NS];
  int n = 0;
  int ck [64];
  int cc [64];
  int cl [64];
  int ct [64];

  keyed_reg_sorter #(.KEY_W(KW), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key),
    .wr_code(wr_code), .start(start), .out_valid(out_valid),
    .out_key(out_key), .out_code(out_code), .out_last(out_last)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && n < 64) begin
      ck[n] = int'(out_key);
      cc[n] = int'(out_code);
      cl[n] = int'(out_last);
      ct[n] = cyc;
      n = n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int k, input int c);
    @(negedge clk);
    wr_en = 1'b1; wr_key = KW'(k); wr_code = CW'(c);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_readout(input bit disturb);
    n = 0;
    @(negedge clk);
    start = 1'b1;
    if (disturb) begin
      wr_en = 1'b1; wr_key = KW'(3); wr_code = 8'h5A;
    end
    @(negedge clk);
    c0 = cyc; start = 1'b0; wr_en = 1'b0;
    if (disturb) begin
      for (int j = 0; j < 4; j++) begin
        wr_en = 1'b1; wr_key = KW'(j + 8); wr_code = 8'hEE; start = (j == 1);
        @(negedge clk);
      end
      wr_en = 1'b0; start = 1'b0;
    end
    repeat (24) @(negedge clk);
  endtask

  task automatic verify(input string req);
    int m = 0;
    int ek [NS];
    int ec [NS];
    for (int k = 0; k < NS; k++) begin
      if (refm[k] != 0) begin
        ek[m] = k; ec[m] = refm[k]; m++;
      end
    end
    chk(n == m, req, "entry count", n, m);
    for (int i = 0; i < m && i < n; i++) begin
      chk(ck[i] == ek[i], "R4", "key order", ck[i], ek[i]);
      chk(cc[i] == ec[i], req, "code", cc[i], ec[i]);
      chk(cl[i] == ((i == m - 1) ? 1 : 0), "R5", "last flag", cl[i], (i == m - 1) ? 1 : 0);
      chk(ct[i] == c0 + 1 + i, "R4", "entry cycle", ct[i], c0 + 1 + i);
    end
  endtask

  initial begin
    for (int k = 0; k < NS; k++) refm[k] = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_key == '0 && out_code == '0 && out_last == 1'b0,
        "R1", "outputs in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    run_readout(1'b0);
    verify("R1");

    // R2: fill every slot
    for (int k = 0; k < NS; k++) begin
      put(k, k * 7 + 3); refm[k] = k * 7 + 3;
    end
    run_readout(1'b0);
    verify("R2");

    // R7 and R8: disturbances during a full readout, then repeat
    run_readout(1'b1);
    verify("R7");
    run_readout(1'b0);
    verify("R8");

    // R2: overwrite
    put(5, 8'h11); put(5, 8'h22); refm[5] = 8'h22;
    run_readout(1'b0);
    verify("R2");

    // R3: occupancy sweep, zero codes empty slots
    for (int i = 0; i < 24; i++) begin
      int mask;
      mask = (i * 40503 + 4660) & 16'hFFFF;
      if (i == 0) mask = 16'h8000;
      if (i == 1) mask = 16'h0001;
      for (int k = 0; k < NS; k++) begin
        int c;
        c = ((mask >> k) & 1) != 0 ? ((k * 13 + i * 5) % 255) + 1 : 0;
        put(k, c); refm[k] = c;
      end
      run_readout(1'b0);
      verify("R3");
    end

    // R6: empty store, write right after the start edge
    for (int k = 0; k < NS; k++) begin
      put(k, 0); refm[k] = 0;
    end
    n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; wr_en = 1'b1; wr_key = KW'(9); wr_code = 8'h44;
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(n == 0, "R6", "empty readout entries", n, 0);
    refm[9] = 8'h44;
    run_readout(1'b0);
    verify("R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule